// File: doc/BRIEF.md
# Dual-Clock Serial Result Output Port

This block moves a 16-bit conversion result off chip through a single serial data pin. It is the digital back end of a converter, and the conversion engine itself is not part of it. The port can clock the data out in two ways. In internal-clock mode it makes its own data clock. A convert request (chip select low together with convert/read low) starts a burst of 16 clock pulses that carries the result of the previous conversion, most significant bit first, while the new conversion runs. In external-clock mode the host supplies the data clock. The word is shifted out only while the host selects the part for reading.

Data bits change on a falling data-clock edge, so each bit is steady when the receiver samples it on the next rising edge. In external mode the chain does not stop after 16 bits. Bits sampled from the tag input are shifted in behind the word, so several ports can be chained. A sync output marks the first clock pulse of each word. A parallel/serial select input turns the serial path off completely when the parallel bus is in use. The internal data-clock half period is a parameter counted in system clocks. The external clock is brought into the system clock domain by a two-flop synchronizer.

Top module: `ser_result_port`

## Requirements
- R1: `dclk_dir` is 1 (data clock pin is an output) when `ext_mode` is 0 and 0 when `ext_mode` is 1. In external mode `dclk_out` stays low from the second cycle onward.
- R2: In internal mode, with `par_mode` low, a falling edge of the condition (`cs_n`=0 and `rd_nconv`=0) while idle produces exactly 16 `dclk_out` pulses. Each pulse period is 2*HALF_DIV system clocks. Afterwards `dclk_out` rests low until the next request.
- R3: In internal mode the bits of `result` captured at the request appear on `sdata` MSB first, one per pulse. `sdata` changes only when `dclk_out` falls, so it is stable while `dclk_out` is high.
- R4: In internal mode `sdata_oe` equals NOT `busy` (enabled while busy is low).
- R5: In external mode `sdata_oe` is 1 exactly when `cs_n`=0 and `rd_nconv`=1.
- R6: In external mode the start of selection captures `result`. Its MSB is on `sdata` before the first `ext_dclk` rise, and each later bit follows a falling `ext_dclk` edge.
- R7: In external mode, `ext_dclk` falling edges after the 16th bit present the `tag_in` values sampled at earlier falling edges, in order: the value sampled at the first falling edge appears as bit 17.
- R8: `sync` is high only for the high phase of the first data-clock pulse of a word. In internal mode it lags `dclk_out` by one system clock and stays high for HALF_DIV cycles.
- R9: With `par_mode`=1, `sdata_oe` is 0 and a convert request produces no `dclk_out` pulse.
- R10: A request made while a burst is already running is ignored, so the burst keeps its count and its data.
- R11: After reset `dclk_out`, `sync` and `sdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | 1 selects the parallel bus; serial path disabled |
| ext_mode | input | 1 | 0 internal data clock, 1 external data clock |
| cs_n | input | 1 | Chip select, active low |
| rd_nconv | input | 1 | 0 requests a conversion, 1 reads |
| busy | input | 1 | Converter state, low while converting |
| ext_dclk | input | 1 | Host data clock in external mode |
| tag_in | input | 1 | Serial input chained behind the word |
| result | input | 16 | Result of the previous conversion |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Output enable for sdata |
| dclk_out | output | 1 | Internal data clock |
| dclk_dir | output | 1 | 1 when the data clock pin drives |
| sync | output | 1 | Start-of-word marker |

## Verification
The properties assume the mode inputs do not change while a burst is running. They also assume the host's external clock is slow compared with the system clock, so each of its phases lasts several system cycles. The stimulus meets these assumptions. Mode changes and random input mixes happen only while the port is idle or in phases that check only enables, and each is followed by an idle wait. The external clock is driven with six-cycle phases. The tag input and the result change only at the external rising edge, well away from the falling edges where they are sampled.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
    localparam int unsigned SP_WORD_W = 16;

    // external clock synchronizer stages
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } xsync_t;

    // top-level request edge memory and sync marker
    typedef struct packed {
        logic conv_prev;
        logic sel_prev;
        logic sync;
    } top_st_t;
endpackage

// File: rtl/sp_xclk_sync.sv
module sp_xclk_sync
    import ser_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_dclk,
    output logic x_lvl,
    output logic x_fall
);
    xsync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ext_dclk;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_lvl  = st_q.s2;
    assign x_fall = st_q.s3 & ~st_q.s2;
endmodule

// File: rtl/sp_int_clkgen.sv
module sp_int_clkgen #(
    parameter int unsigned HALF_DIV = 4,
    parameter int unsigned WORD_W   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic dclk,
    output logic fall,
    output logic running,
    output logic first_hi
);
    localparam int unsigned DW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam int unsigned CW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic          run;
        logic [DW-1:0] div;
        logic          dclk;
        logic [CW-1:0] cnt;
    } gen_t;

    gen_t g_d, g_q;
    logic fall_c;

    always_comb begin
        g_d    = g_q;
        fall_c = 1'b0;
        if (abort) begin
            g_d = '0;
        end else if (!g_q.run) begin
            if (start) begin
                g_d.run  = 1'b1;
                g_d.div  = '0;
                g_d.dclk = 1'b0;
                g_d.cnt  = '0;
            end
        end else if (g_q.div == DW'(HALF_DIV - 1)) begin
            g_d.div  = '0;
            g_d.dclk = ~g_q.dclk;
            if (g_q.dclk) begin
                fall_c  = 1'b1;
                g_d.cnt = g_q.cnt + 1'b1;
                if (g_q.cnt == CW'(WORD_W - 1)) g_d.run = 1'b0;
            end
        end else begin
            g_d.div = g_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign dclk     = g_q.dclk;
    assign fall     = fall_c;
    assign running  = g_q.run;
    assign first_hi = g_q.run & g_q.dclk & (g_q.cnt == '0);
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              shift,
    input  logic              din,
    output logic              msb,
    output logic              at_first
);
    localparam int unsigned CW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CW-1:0]     cnt;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sr  = load_val;
            s_d.cnt = '0;
        end else if (shift) begin
            s_d.sr = {s_q.sr[WORD_W-2:0], din};
            if (s_q.cnt != CW'(WORD_W)) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msb      = s_q.sr[WORD_W-1];
    assign at_first = (s_q.cnt == '0);
endmodule

// File: rtl/ser_result_port.sv
module ser_result_port
    import ser_port_pkg::*;
#(
    parameter int unsigned WORD_W   = SP_WORD_W,
    parameter int unsigned HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_mode,
    input  logic              ext_mode,
    input  logic              cs_n,
    input  logic              rd_nconv,
    input  logic              busy,
    input  logic              ext_dclk,
    input  logic              tag_in,
    input  logic [WORD_W-1:0] result,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              dclk_out,
    output logic              dclk_dir,
    output logic              sync
);
    top_st_t t_d, t_q;

    logic int_en, conv_lvl, conv_start, sel, sel_start;
    logic gen_fall, gen_run, gen_first, gen_dclk;
    logic x_lvl, x_fall;
    logic sh_load, sh_shift, sh_din, sh_first;

    assign int_en     = ~ext_mode & ~par_mode;
    assign conv_lvl   = int_en & ~cs_n & ~rd_nconv;
    assign conv_start = conv_lvl & ~t_q.conv_prev;
    assign sel        = ext_mode & ~par_mode & ~cs_n & rd_nconv;
    assign sel_start  = sel & ~t_q.sel_prev;

    sp_xclk_sync u_xs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_dclk (ext_dclk),
        .x_lvl    (x_lvl),
        .x_fall   (x_fall)
    );

    sp_int_clkgen #(.HALF_DIV(HALF_DIV), .WORD_W(WORD_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (conv_start),
        .abort    (~int_en),
        .dclk     (gen_dclk),
        .fall     (gen_fall),
        .running  (gen_run),
        .first_hi (gen_first)
    );

    assign sh_load  = (conv_start & ~gen_run) | sel_start;
    assign sh_shift = gen_fall | (sel & x_fall);
    assign sh_din   = ext_mode & tag_in;

    sp_shifter #(.WORD_W(WORD_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (result),
        .shift    (sh_shift),
        .din      (sh_din),
        .msb      (sdata),
        .at_first (sh_first)
    );

    always_comb begin
        t_d           = t_q;
        t_d.conv_prev = conv_lvl;
        t_d.sel_prev  = sel;
        if (ext_mode) t_d.sync = sel & x_lvl & sh_first;
        else          t_d.sync = gen_first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign sdata_oe = ~par_mode & (ext_mode ? (~cs_n & rd_nconv) : ~busy);
    assign dclk_out = gen_dclk;
    assign dclk_dir = ~ext_mode;
    assign sync     = t_q.sync;
endmodule

// File: rtl/sp_port_chk.sv
module sp_port_chk (
    input logic clk,
    input logic rst_n,
    input logic par_mode,
    input logic ext_mode,
    input logic cs_n,
    input logic rd_nconv,
    input logic busy,
    input logic sdata,
    input logic sdata_oe,
    input logic dclk_out,
    input logic sync
);
    p_ext_clk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode && $past(ext_mode) |-> !dclk_out);

    p_stable_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode && dclk_out && $past(dclk_out) |-> $stable(sdata));

    p_oe_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode && busy |-> !sdata_oe);

    p_oe_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode && (cs_n || !rd_nconv) |-> !sdata_oe);

    p_sync_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode && !$past(ext_mode) && !dclk_out && !$past(dclk_out) |-> !sync);

    p_par_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode |-> !sdata_oe);
endmodule

bind ser_result_port sp_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .ext_mode (ext_mode),
    .cs_n     (cs_n),
    .rd_nconv (rd_nconv),
    .busy     (busy),
    .sdata    (sdata),
    .sdata_oe (sdata_oe),
    .dclk_out (dclk_out),
    .sync     (sync)
);

// File: tb/sim_ser_result_port.sv
`timescale 1ns/1ps
module sim_ser_result_port;
    localparam int W  = 16;
    localparam int HD = 4;
    localparam int XH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic par_mode = 1'b0, ext_mode = 1'b0, cs_n = 1'b1, rd_nconv = 1'b1;
    logic busy = 1'b1, ext_dclk = 1'b0, tag_in = 1'b0;
    logic [W-1:0] result = '0;
    logic sdata, sdata_oe, dclk_out, dclk_dir, sync;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ser_result_port #(.WORD_W(W), .HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .ext_mode(ext_mode),
        .cs_n(cs_n), .rd_nconv(rd_nconv), .busy(busy), .ext_dclk(ext_dclk),
        .tag_in(tag_in), .result(result), .sdata(sdata), .sdata_oe(sdata_oe),
        .dclk_out(dclk_out), .dclk_dir(dclk_dir), .sync(sync)
    );

    function automatic logic exp_oe(logic pm, logic em, logic cs, logic rc, logic bz);
        if (pm) return 1'b0;
        if (em) return ~cs & rc;
        return ~bz;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // internal-clock word; optional second request mid-burst (R10)
    task automatic run_int(logic [W-1:0] val, bit again);
        int rises = 0, syncn = 0, last = 0;
        logic prev = 1'b0;
        @(negedge clk);
        result = val; busy = 1'b0; cs_n = 1'b0; rd_nconv = 1'b0;
        @(negedge clk);
        result = ~val; cs_n = 1'b1; rd_nconv = 1'b1;
        chk(sdata_oe == 1'b1, "R4", sdata_oe, 1);
        for (int c = 0; c < 2 * HD * W + 4 * HD + 10; c++) begin
            @(negedge clk);
            if (again && c == 40) begin cs_n = 1'b0; rd_nconv = 1'b0; end
            if (again && c == 42) begin cs_n = 1'b1; rd_nconv = 1'b1; end
            if (dclk_out && !prev) begin
                if (rises < W)
                    chk(sdata == val[W-1-rises], again ? "R10" : "R3", sdata, val[W-1-rises]);
                if (rises > 0) chk(c - last == 2 * HD, "R2", c - last, 2 * HD);
                last = c;
                rises++;
            end
            if (sync) syncn++;
            prev = dclk_out;
        end
        chk(rises == W, again ? "R10" : "R2", rises, W);
        chk(syncn == HD, "R8", syncn, HD);
        chk(dclk_out == 1'b0, "R2", dclk_out, 0);
        busy = 1'b1;
        @(negedge clk);
        chk(sdata_oe == 1'b0, "R4", sdata_oe, 0);
    endtask

    // external-clock word followed by tag bits
    task automatic run_ext(logic [W-1:0] val, int nb);
        logic [15:0] tags;
        int syncn = 0;
        logic e;
        tags = 16'($urandom);
        @(negedge clk);
        ext_mode = 1'b1; result = val; cs_n = 1'b0; rd_nconv = 1'b1; ext_dclk = 1'b0;
        idle(4);
        result = ~val;
        chk(sdata_oe == 1'b1, "R5", sdata_oe, 1);
        chk(dclk_dir == 1'b0, "R1", dclk_dir, 0);
        chk(dclk_out == 1'b0, "R1", dclk_out, 0);
        for (int i = 0; i < nb; i++) begin
            e = (i < W) ? val[W-1-i] : tags[i-W];
            chk(sdata == e, (i < W) ? "R6" : "R7", sdata, e);
            tag_in = tags[i];
            ext_dclk = 1'b1;
            for (int k = 0; k < XH; k++) begin @(negedge clk); if (sync) syncn++; end
            ext_dclk = 1'b0;
            for (int k = 0; k < XH; k++) begin @(negedge clk); if (sync) syncn++; end
        end
        chk(syncn == XH, "R8", syncn, XH);
        cs_n = 1'b1;
        @(negedge clk);
        chk(sdata_oe == 1'b0, "R5", sdata_oe, 0);
        ext_mode = 1'b0;
        idle(4);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        idle(3);
        chk(dclk_out == 1'b0, "R11", dclk_out, 0);
        chk(sync == 1'b0, "R11", sync, 0);
        chk(sdata == 1'b0, "R11", sdata, 0);
        rst_n = 1'b1;
        idle(3);
        chk(dclk_dir == 1'b1, "R1", dclk_dir, 1);

        // directed corner words
        run_int(16'h8001, 1'b0);
        run_int(16'hFFFF, 1'b0);
        run_int(16'h0000, 1'b0);
        run_int(16'hA5C3, 1'b1);
        for (int n = 0; n < 4; n++) run_int(16'($urandom), n[0]);

        run_ext(16'h7FFE, 24);
        for (int n = 0; n < 3; n++) run_ext(16'($urandom), 16 + n * 5);

        // parallel select blocks the serial path
        begin
            int rises = 0;
            logic prev = 1'b0;
            @(negedge clk);
            par_mode = 1'b1; busy = 1'b0; cs_n = 1'b0; rd_nconv = 1'b0;
            @(negedge clk);
            chk(sdata_oe == 1'b0, "R9", sdata_oe, 0);
            for (int c = 0; c < 8 * HD; c++) begin
                @(negedge clk);
                if (dclk_out && !prev) rises++;
                prev = dclk_out;
            end
            chk(rises == 0, "R9", rises, 0);
            cs_n = 1'b1; rd_nconv = 1'b1; busy = 1'b1; par_mode = 1'b0;
            idle(4);
        end

        // random enable mix
        for (int n = 0; n < 60; n++) begin
            logic e;
            @(negedge clk);
            {par_mode, ext_mode, cs_n, rd_nconv, busy} = 5'($urandom);
            #1;
            e = exp_oe(par_mode, ext_mode, cs_n, rd_nconv, busy);
            chk(sdata_oe == e, ext_mode ? "R5" : (par_mode ? "R9" : "R4"), sdata_oe, e);
            chk(dclk_dir == ~ext_mode, "R1", dclk_dir, ~ext_mode);
        end
        @(negedge clk);
        par_mode = 1'b0; ext_mode = 1'b0; cs_n = 1'b1; rd_nconv = 1'b1; busy = 1'b1;
        idle(2 * HD * W + 20);
        chk(dclk_out == 1'b0, "R2", dclk_out, 0);
        run_int(16'h3C96, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule